// File: doc/BRIEF.md
# Offset Threshold Register Loader

This block keeps the two programmable threshold values that a FIFO flag comparator needs: an almost-empty offset and an almost-full offset. Each offset is stored as two 8-bit bytes, which gives four byte registers in total. Software or a controller loads them one byte at a time over the FIFO write data port. While the load control is active, the ordinary write enable acts as a load strobe, and the ordinary read enables act as a read-back strobe.

One shared 2-bit selection pointer decides which byte the next access uses. Both write and read accesses advance it, and it wraps after the last byte. When loading is paused, the pointer keeps its value, so a partial load resumes where it stopped. The block outputs both assembled thresholds continuously. It also drives a registered read-back byte toward the FIFO output register. This is a single-clock build, so writes and read-back share one pointer.

Top module: `offs_loader`

## Requirements
- R1: After reset, both thresholds equal 7 and `rd_data` is 0. The first load write lands in the almost-empty low byte.
- R2: When `load_n`=0 and `wen_n`=0 at a rising clock edge, `din` is written into the selected byte, and the selection advances by one.
- R3: Selection codes are 0 = empty low, 1 = empty high, 2 = full low, 3 = full high, and accesses visit them in that order.
- R4: After the full high byte (code 3), the next access selects the empty low byte (code 0).
- R5: When `load_n`=1, write and read strobes change neither the bytes nor the selection. A later load access continues at the next byte in sequence.
- R6: When `load_n`=0, `wen_n`=1, `ren1_n`=0 and `ren2_n`=0 at a rising edge, the selected byte is registered onto `rd_data`, and the selection advances by one.
- R7: When no read access occurs, `rd_data` holds its value. This includes the cases where either read enable is high.
- R8: A write and a read in the same cycle is handled as a write only. `rd_data` holds, and the selection advances once.
- R9: `empty_thr` = {empty high, empty low}[THR_W-1:0] and `full_thr` = {full high, full low}[THR_W-1:0], where THR_W = log2(DEPTH). These outputs follow a write after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and read-back |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_n | input | 1 | Active-low offset access select |
| wen_n | input | 1 | Active-low write strobe |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| din | input | BYTE_W | Byte to load |
| rd_data | output | BYTE_W | Registered read-back byte |
| empty_thr | output | THR_W | Almost-empty threshold |
| full_thr | output | THR_W | Almost-full threshold |

## Verification
A load write and a read-back can be requested in the same cycle. Both of them would move the shared pointer. The bench provokes this by asserting `wen_n` and both read enables low together with `load_n` low, both in directed steps and inside a sweep over all sixteen strobe combinations. It judges the result against a byte-level model: the byte must be written, `rd_data` must not change, and the pointer must move by exactly one step. The next access then shows where the pointer landed.

// File: rtl/offs_pkg.sv
package offs_pkg;
  localparam int NUM_BYTES = 4;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } sel_e;
endpackage

// File: rtl/offs_rst_sync.sv
module offs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/offs_sel_ptr.sv
module offs_sel_ptr
  import offs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output sel_e sel
);
  sel_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (adv) sel_d = sel_e'(sel_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_EMPTY_LO;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;
endmodule

// File: rtl/offs_reg_bank.sv
module offs_reg_bank
  import offs_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF  = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  sel_e                            sel,
  input  logic [BYTE_W-1:0]               din,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0] regs_q
);
  localparam logic [2*BYTE_W-1:0] E_DEF = (2*BYTE_W)'(EMPTY_DEF);
  localparam logic [2*BYTE_W-1:0] F_DEF = (2*BYTE_W)'(FULL_DEF);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [2*BYTE_W-1:0] PAIR = (i < 2) ? E_DEF : F_DEF;
    localparam logic [BYTE_W-1:0]   RST_V =
      (i % 2 == 0) ? PAIR[BYTE_W-1:0] : PAIR[2*BYTE_W-1:BYTE_W];
    logic              hit;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      hit    = wr_en && (sel == sel_e'(i));
      byte_d = regs_q[i];
      if (hit) byte_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= RST_V;
      else        regs_q[i] <= byte_d;
    end
  end
endmodule

// File: rtl/offs_loader.sv
module offs_loader
  import offs_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DEPTH     = 1024,
  parameter int EMPTY_DEF = 7,
  parameter int FULL_DEF  = 7,
  localparam int THR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rd_data,
  output logic [THR_W-1:0]  empty_thr,
  output logic [THR_W-1:0]  full_thr
);
  logic                             rst_n_s;
  logic                             wr_acc, rd_acc;
  sel_e                             sel;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] regs_q;
  logic [BYTE_W-1:0]                rd_q, rd_d;
  logic [2*BYTE_W-1:0]              e_cat, f_cat;

  offs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  // write wins a collision; read-back is suppressed then
  assign wr_acc = !load_n && !wen_n;
  assign rd_acc = !load_n && !ren1_n && !ren2_n && !wr_acc;

  offs_sel_ptr u_ptr (
    .clk(clk), .rst_n(rst_n_s), .adv(wr_acc || rd_acc), .sel(sel)
  );

  offs_reg_bank #(
    .BYTE_W(BYTE_W), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_acc), .sel(sel),
    .din(din), .regs_q(regs_q)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_acc) rd_d = regs_q[sel];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rd_q <= '0;
    else          rd_q <= rd_d;
  end

  assign rd_data   = rd_q;
  assign e_cat     = {regs_q[SEL_EMPTY_HI], regs_q[SEL_EMPTY_LO]};
  assign f_cat     = {regs_q[SEL_FULL_HI],  regs_q[SEL_FULL_LO]};
  assign empty_thr = e_cat[THR_W-1:0];
  assign full_thr  = f_cat[THR_W-1:0];
endmodule

// File: rtl/offs_loader_chk.sv
module offs_loader_chk
  import offs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int THR_W  = 10
) (
  input logic                             clk,
  input logic                             rst_ns,
  input logic                             load_n,
  input logic                             wen_n,
  input logic                             ren1_n,
  input logic                             ren2_n,
  input sel_e                             sel,
  input logic [NUM_BYTES-1:0][BYTE_W-1:0] regs_q,
  input logic [BYTE_W-1:0]                rd_data,
  input logic [THR_W-1:0]                 empty_thr,
  input logic [THR_W-1:0]                 full_thr
);
  logic wr_req, rd_req;
  assign wr_req = !load_n && !wen_n;
  assign rd_req = !load_n && !ren1_n && !ren2_n;

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_req || rd_req) |=> sel == sel_e'($past(sel) + 2'd1));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    load_n |=> $stable(sel));

  // R6
  rd_val_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_req && !wr_req) |=> rd_data == $past(regs_q[sel]));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_req |=> $stable(rd_data));

  // R8
  coll_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_req && rd_req) |=> $stable(rd_data));

  // R9
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_req |=> ($stable(empty_thr) && $stable(full_thr)));

  always @(posedge clk)
    if (rst_ns && wr_req && rd_req)
      $warning("offset access collision: handled as write");
endmodule

bind offs_loader offs_loader_chk #(.BYTE_W(BYTE_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_ns(rst_n_s), .load_n(load_n), .wen_n(wen_n),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .sel(sel), .regs_q(regs_q),
  .rd_data(rd_data), .empty_thr(empty_thr), .full_thr(full_thr)
);

// File: tb/offs_loader_tb.sv
module offs_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int TW = 10;

  logic clk = 1'b0;
  logic rst_n, load_n, wen_n, ren1_n, ren2_n;
  logic [BW-1:0] din, rd_data;
  logic [TW-1:0] empty_thr, full_thr;

  int checks = 0, fails = 0;
  logic [BW-1:0] m_reg [4];
  int m_ptr;
  logic [BW-1:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  offs_loader u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .rd_data(rd_data),
    .empty_thr(empty_thr), .full_thr(full_thr)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(int lo);
    return ({m_reg[lo+1], m_reg[lo]}) & ((1 << TW) - 1);
  endfunction

  // one cycle: drive after negedge, compare after the following posedge
  task automatic step(logic ld, logic we, logic r1, logic r2, logic [BW-1:0] d,
                      string tag);
    bit wr, rd;
    load_n = ld; wen_n = we; ren1_n = r1; ren2_n = r2; din = d;
    wr = !ld && !we;
    rd = !ld && !r1 && !r2 && !wr;
    @(negedge clk);
    if (wr) m_reg[m_ptr] = d;
    if (rd) m_rd = m_reg[m_ptr];
    if (wr || rd) m_ptr = (m_ptr + 1) % 4;
    chk({tag, " rd_data"}, int'(rd_data), int'(m_rd));
    chk("R9 empty_thr", int'(empty_thr), thr_of(0));
    chk("R9 full_thr", int'(full_thr), thr_of(2));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; wen_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    din = '0;
    m_reg[0] = 8'd7; m_reg[1] = 8'd0; m_reg[2] = 8'd7; m_reg[3] = 8'd0;
    m_ptr = 0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty_thr", int'(empty_thr), 7);
    chk("R1 full_thr", int'(full_thr), 7);
    chk("R1 rd_data", int'(rd_data), 0);
    // R1 R3 first write lands in empty low byte
    step(0, 0, 1, 1, 8'hA5, "R3");
    chk("R1 R3 empty low written", int'(empty_thr), 10'h0A5);
    step(0, 0, 1, 1, 8'h02, "R3");
    chk("R3 empty high written", int'(empty_thr), 10'h2A5);
    // R5 pause: strobes with load high do nothing
    step(1, 0, 0, 0, 8'hFF, "R5");
    step(1, 0, 1, 1, 8'hEE, "R5");
    chk("R5 empty kept", int'(empty_thr), 10'h2A5);
    chk("R5 full kept", int'(full_thr), 7);
    step(0, 0, 1, 1, 8'h3C, "R5");
    chk("R5 resume at full low", int'(full_thr), 10'h03C);
    step(0, 0, 1, 1, 8'h01, "R3");
    chk("R3 full high written", int'(full_thr), 10'h13C);
    // R4 wrap to empty low
    step(0, 0, 1, 1, 8'h11, "R4");
    chk("R4 wrap empty low", int'(empty_thr), 10'h211);
    // R6 read-back in order starting at empty high
    step(0, 1, 0, 0, 8'h00, "R6");
    chk("R6 read empty high", int'(rd_data), 8'h02);
    step(0, 1, 1, 0, 8'h00, "R7");
    step(0, 1, 0, 1, 8'h00, "R7");
    chk("R7 held", int'(rd_data), 8'h02);
    step(0, 1, 0, 0, 8'h00, "R6");
    chk("R6 read full low", int'(rd_data), 8'h3C);
    // R8 collision: write full high, rd holds
    step(0, 0, 0, 0, 8'h03, "R8");
    chk("R8 rd held", int'(rd_data), 8'h3C);
    chk("R8 written", int'(full_thr), 10'h33C);
    step(0, 1, 0, 0, 8'h00, "R8");
    chk("R8 single advance", int'(rd_data), 8'h11);
    // sweep over all strobe combinations
    for (int n = 0; n < 640; n++) begin
      logic [3:0] c;
      c = 4'(n % 16);
      step(c[3], c[2], c[1], c[0], 8'((n * 37 + 5) & 255),
           (!c[3] && !c[2]) ? ((!c[1] && !c[0]) ? "R8" : "R2") :
           (!c[3] && !c[1] && !c[0]) ? "R6" : (c[3] ? "R5" : "R7"));
    end
    // R1 reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 re-reset empty", int'(empty_thr), 7);
    chk("R1 re-reset rd", int'(rd_data), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule